// File: doc/BRIEF.md
# Compound Read-Modify-Write Logic Unit

This unit evaluates the fused operations of an 8-bit accumulator processor. Each of these operations first alters a memory operand, then combines the altered value with a register. The same family also covers a set of masking operations that AND registers with fixed constants. For every operation code the unit produces two things: the byte to write back to memory, and the new register contents together with the N, Z, C and V flags. Each result has its own write enable.

The caller presents an operation code, the A, X, Y and S registers, the memory operand, the carry flag and the decimal-mode flag. One clock later the unit presents the registered results. A single shared adder serves every operation that needs arithmetic: the rotate-then-add, the increment-then-subtract, the decrement-then-compare and the masked X subtract. Bus sequencing and address generation belong to the surrounding core.

Top module: `rmw_unit`

## Requirements
- R1: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. While reset is high, every output is 0 on the next edge.
- R2: Ops 0, 1 and 2 write a memory value and update A and C.
  - Op 0: memory = M shifted left with a 0 entering bit 0, then A = A OR memory.
  - Op 1: memory = M shifted left with C entering bit 0, then A = A AND memory.
  - Op 2: memory = M shifted right with a 0 entering bit 7, then A = A XOR memory.
  - C takes the bit shifted out of M.
- R3: With the decimal flag at 0, op 3 rotates M right with the old C entering bit 7 and stores the result. It then adds that result to A, using bit 0 of M as the carry-in. C is the carry-out and V is the signed overflow.
- R4: With the decimal flag at 1, op 3 adds nibble by nibble, starting with the low nibble.
  - A nibble sum above 9 gets 6 added to it, and the carry passed onward is 1 when the corrected value exceeds 15.
  - N and V come from the high nibble before its correction, and Z comes from the plain binary sum.
- R5: Op 4 stores M−1 and compares A against that value. N and Z come from A−(M−1), and C = 1 when A ≥ M−1. A and V are left unchanged.
- R6: Op 5 stores M+1, then sets A = A − (M+1) − (1−C). N, Z, C and V always follow binary rules. With the decimal flag at 1, a nibble that borrows has 6 subtracted from it.
- R7: Op 6 sets A = A AND M and copies bit 7 of the result into C.
- R8: Op 7 forms T = A AND M and sets A = T shifted right one place, with the old C entering bit 7. C then takes bit 6 of the new A, and V = (A6 AND M6) XOR (A7 AND M7).
- R9: Op 8 sets X = (X AND A) − M, with C = 1 when no borrow occurs. A is unchanged.
- R10: Op 9 writes S AND M into A, X and S.
- R11: Op 10 sets A = (A OR 0xEE) AND X AND M. Op 11 writes (A OR 0xEE) AND M into both A and X.
- R12: Ops 12 to 15 only store, and none of them writes a flag.
  - Op 12 stores A AND X.
  - Op 13 stores X AND 0x07.
  - Op 14 stores Y AND 0x07.
  - Op 15 sets S = A AND X and stores S AND 0x07.
- R13: Write enables mark exactly the destinations an op changes.
  - The memory write enable is set for ops 0–5 and 12–15.
  - The N/Z enable is set for ops 0–11. Outside the adder ops, N and Z follow the final register result.
  - A register or memory output that is not written repeats its input value. A flag that is not written reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (0–15) |
| a_i | input | 8 | Accumulator |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| s_i | input | 8 | Stack pointer |
| m_i | input | 8 | Memory operand |
| c_i | input | 1 | Carry flag in |
| d_i | input | 1 | Decimal-mode flag |
| mem_we_o | output | 1 | Memory write enable |
| mem_o | output | 8 | Memory value |
| a_we_o | output | 1 | A write enable |
| a_o | output | 8 | New A |
| x_we_o | output | 1 | X write enable |
| x_o | output | 8 | New X |
| s_we_o | output | 1 | S write enable |
| s_o | output | 8 | New S |
| nz_we_o | output | 1 | N/Z write enable |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_we_o | output | 1 | Carry write enable |
| c_o | output | 1 | Carry flag out |
| v_we_o | output | 1 | Overflow write enable |
| v_o | output | 1 | Overflow flag |

## Verification
The hardest case is a decimal operation whose operands contain nibbles above 9. There the corrected digit can land in A–F, and a carry raised by the correction must still propagate into the high nibble while N and V are read before that nibble is corrected. A sparse sweep of all sixteen ops places edge values such as 0x00, 0x7F, 0x80 and 0xFF on both operands, with both carry and decimal settings. A separate exhaustive sweep then runs every pair of packed-BCD operands through ops 3 and 5.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
package rmw_pkg;

  typedef enum logic [3:0] {
    OP_SHL_OR   = 4'd0,
    OP_ROL_AND  = 4'd1,
    OP_SHR_XOR  = 4'd2,
    OP_ROR_ADD  = 4'd3,
    OP_DEC_CMP  = 4'd4,
    OP_INC_SUB  = 4'd5,
    OP_AND_CARRY= 4'd6,
    OP_AND_ROR  = 4'd7,
    OP_SUB_XA   = 4'd8,
    OP_LOAD_SM  = 4'd9,
    OP_MASK_AXM = 4'd10,
    OP_MASK_AM  = 4'd11,
    OP_ST_AX    = 4'd12,
    OP_ST_X7    = 4'd13,
    OP_ST_Y7    = 4'd14,
    OP_ST_SAX7  = 4'd15
  } rmw_op_e;

  typedef enum logic [2:0] {
    PRE_PASS = 3'd0,
    PRE_SHL  = 3'd1,
    PRE_ROL  = 3'd2,
    PRE_SHR  = 3'd3,
    PRE_ROR  = 3'd4,
    PRE_INC  = 3'd5,
    PRE_DEC  = 3'd6
  } pre_e;

endpackage

// File: rtl/rmw_premod.sv
`timescale 1ns/1ps
// Memory-side pre-operation: shift, rotate, increment or decrement.
module rmw_premod
  import rmw_pkg::*;
#(
  parameter int W = 8
) (
  input  pre_e         sel_i,
  input  logic [W-1:0] m_i,
  input  logic         c_i,
  output logic [W-1:0] m_o,
  output logic         c_o
);

  always_comb begin
    m_o = m_i;
    c_o = c_i;
    unique case (sel_i)
      PRE_SHL: {c_o, m_o} = {m_i, 1'b0};
      PRE_ROL: {c_o, m_o} = {m_i, c_i};
      PRE_SHR: {m_o, c_o} = {1'b0, m_i};
      PRE_ROR: {m_o, c_o} = {c_i, m_i};
      PRE_INC: m_o = m_i + W'(1);
      PRE_DEC: m_o = m_i - W'(1);
      default: begin
        m_o = m_i;
        c_o = c_i;
      end
    endcase
  end

endmodule

// File: rtl/rmw_adder.sv
`timescale 1ns/1ps
// Shared add/subtract with per-nibble decimal correction.
module rmw_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  input  logic         dec_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o
);

  localparam int NIB = W / 4;

  logic [W-1:0] b_eff;
  logic [W:0]   bsum;
  logic         bin_v;
  logic [W-1:0] dsum;
  logic         dcarry;
  logic [3:0]   top_raw;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign bsum  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign bin_v = (a_i[W-1] == b_eff[W-1]) && (bsum[W-1] != a_i[W-1]);

  always_comb begin
    logic [5:0] raw;
    logic       chain;
    logic       brw;
    dsum    = '0;
    top_raw = '0;
    chain   = cin_i;
    brw     = ~cin_i;
    raw     = '0;
    for (int i = 0; i < NIB; i++) begin
      if (!sub_i) begin
        raw = 6'(a_i[i*4 +: 4]) + 6'(b_i[i*4 +: 4]) + 6'(chain);
        if (i == NIB - 1) top_raw = raw[3:0];
        if (raw > 6'd9) raw = raw + 6'd6;
        chain = (raw > 6'd15);
      end else begin
        raw = 6'(a_i[i*4 +: 4]) - 6'(b_i[i*4 +: 4]) - 6'(brw);
        brw = raw[5];
        if (brw) raw = raw - 6'd6;
      end
      dsum[i*4 +: 4] = raw[3:0];
    end
    dcarry = chain;
  end

  always_comb begin
    z_o = (bsum[W-1:0] == '0);
    if (dec_i && !sub_i) begin
      sum_o  = dsum;
      cout_o = dcarry;
      n_o    = top_raw[3];
      v_o    = (a_i[W-1] == b_i[W-1]) && (top_raw[3] != a_i[W-1]);
    end else begin
      sum_o  = dec_i ? dsum : bsum[W-1:0];
      cout_o = bsum[W];
      n_o    = bsum[W-1];
      v_o    = bin_v;
    end
  end

endmodule

// File: rtl/rmw_unit.sv
`timescale 1ns/1ps
// Compound read-modify-write logic unit, one registered stage.
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] LOW_MASK = W'('h07),
  parameter logic [W-1:0] OR_CONST = W'('hEE)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] m_i,
  input  logic         c_i,
  input  logic         d_i,
  output logic         mem_we_o,
  output logic [W-1:0] mem_o,
  output logic         a_we_o,
  output logic [W-1:0] a_o,
  output logic         x_we_o,
  output logic [W-1:0] x_o,
  output logic         s_we_o,
  output logic [W-1:0] s_o,
  output logic         nz_we_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_we_o,
  output logic         c_o,
  output logic         v_we_o,
  output logic         v_o
);

  rmw_op_e      op;
  pre_e         pre_sel;
  logic [W-1:0] pre_m;
  logic         pre_c;

  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_cin, add_sub, add_dec, add_cout, add_n, add_z, add_v;

  logic         nx_mem_we, nx_a_we, nx_x_we, nx_s_we, nx_nz_we, nx_c_we, nx_v_we;
  logic [W-1:0] nx_mem, nx_a, nx_x, nx_s;
  logic         nx_n, nx_z, nx_c, nx_v;

  assign op = rmw_op_e'(op_i);

  always_comb begin
    unique case (op)
      OP_SHL_OR:  pre_sel = PRE_SHL;
      OP_ROL_AND: pre_sel = PRE_ROL;
      OP_SHR_XOR: pre_sel = PRE_SHR;
      OP_ROR_ADD: pre_sel = PRE_ROR;
      OP_DEC_CMP: pre_sel = PRE_DEC;
      OP_INC_SUB: pre_sel = PRE_INC;
      default:    pre_sel = PRE_PASS;
    endcase
  end

  rmw_premod #(.W(W)) u_pre (
    .sel_i (pre_sel),
    .m_i   (m_i),
    .c_i   (c_i),
    .m_o   (pre_m),
    .c_o   (pre_c)
  );

  always_comb begin
    add_a   = a_i;
    add_b   = pre_m;
    add_cin = c_i;
    add_sub = 1'b0;
    add_dec = 1'b0;
    unique case (op)
      OP_ROR_ADD: begin
        add_cin = pre_c;
        add_dec = d_i;
      end
      OP_INC_SUB: begin
        add_sub = 1'b1;
        add_dec = d_i;
      end
      OP_DEC_CMP: begin
        add_cin = 1'b1;
        add_sub = 1'b1;
      end
      OP_SUB_XA: begin
        add_a   = x_i & a_i;
        add_b   = m_i;
        add_cin = 1'b1;
        add_sub = 1'b1;
      end
      default: ;
    endcase
  end

  rmw_adder #(.W(W)) u_add (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sub_i  (add_sub),
    .dec_i  (add_dec),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .n_o    (add_n),
    .z_o    (add_z),
    .v_o    (add_v)
  );

  always_comb begin
    logic [W-1:0] t;
    logic [W-1:0] nz_src;
    logic         nz_from_add;
    t           = a_i & m_i;
    nz_src      = '0;
    nz_from_add = 1'b0;
    nx_mem_we = 1'b0; nx_mem = m_i;
    nx_a_we   = 1'b0; nx_a   = a_i;
    nx_x_we   = 1'b0; nx_x   = x_i;
    nx_s_we   = 1'b0; nx_s   = s_i;
    nx_nz_we  = 1'b0; nx_c_we = 1'b0; nx_v_we = 1'b0;
    nx_n = 1'b0; nx_z = 1'b0; nx_c = 1'b0; nx_v = 1'b0;
    unique case (op)
      OP_SHL_OR, OP_ROL_AND, OP_SHR_XOR: begin
        nx_mem_we = 1'b1; nx_mem = pre_m;
        nx_a_we   = 1'b1;
        if (op == OP_SHL_OR)       nx_a = a_i | pre_m;
        else if (op == OP_ROL_AND) nx_a = a_i & pre_m;
        else                       nx_a = a_i ^ pre_m;
        nx_c_we = 1'b1; nx_c = pre_c;
        nx_nz_we = 1'b1; nz_src = nx_a;
      end
      OP_ROR_ADD, OP_INC_SUB: begin
        nx_mem_we = 1'b1; nx_mem = pre_m;
        nx_a_we   = 1'b1; nx_a   = add_sum;
        nx_c_we = 1'b1; nx_c = add_cout;
        nx_v_we = 1'b1; nx_v = add_v;
        nx_nz_we = 1'b1; nz_from_add = 1'b1;
      end
      OP_DEC_CMP: begin
        nx_mem_we = 1'b1; nx_mem = pre_m;
        nx_c_we = 1'b1; nx_c = add_cout;
        nx_nz_we = 1'b1; nz_from_add = 1'b1;
      end
      OP_AND_CARRY: begin
        nx_a_we = 1'b1; nx_a = t;
        nx_c_we = 1'b1; nx_c = t[W-1];
        nx_nz_we = 1'b1; nz_src = t;
      end
      OP_AND_ROR: begin
        nx_a_we = 1'b1; nx_a = {c_i, t[W-1:1]};
        nx_c_we = 1'b1; nx_c = t[W-1];
        nx_v_we = 1'b1; nx_v = t[W-1] ^ t[W-2];
        nx_nz_we = 1'b1; nz_src = {c_i, t[W-1:1]};
      end
      OP_SUB_XA: begin
        nx_x_we = 1'b1; nx_x = add_sum;
        nx_c_we = 1'b1; nx_c = add_cout;
        nx_nz_we = 1'b1; nz_from_add = 1'b1;
      end
      OP_LOAD_SM: begin
        nx_a_we = 1'b1; nx_a = s_i & m_i;
        nx_x_we = 1'b1; nx_x = s_i & m_i;
        nx_s_we = 1'b1; nx_s = s_i & m_i;
        nx_nz_we = 1'b1; nz_src = s_i & m_i;
      end
      OP_MASK_AXM: begin
        nx_a_we = 1'b1; nx_a = (a_i | OR_CONST) & x_i & m_i;
        nx_nz_we = 1'b1; nz_src = nx_a;
      end
      OP_MASK_AM: begin
        nx_a_we = 1'b1; nx_a = (a_i | OR_CONST) & m_i;
        nx_x_we = 1'b1; nx_x = (a_i | OR_CONST) & m_i;
        nx_nz_we = 1'b1; nz_src = nx_a;
      end
      OP_ST_AX: begin
        nx_mem_we = 1'b1; nx_mem = a_i & x_i;
      end
      OP_ST_X7: begin
        nx_mem_we = 1'b1; nx_mem = x_i & LOW_MASK;
      end
      OP_ST_Y7: begin
        nx_mem_we = 1'b1; nx_mem = y_i & LOW_MASK;
      end
      OP_ST_SAX7: begin
        nx_s_we   = 1'b1; nx_s   = a_i & x_i;
        nx_mem_we = 1'b1; nx_mem = a_i & x_i & LOW_MASK;
      end
      default: ;
    endcase
    if (nx_nz_we) begin
      nx_n = nz_from_add ? add_n : nz_src[W-1];
      nx_z = nz_from_add ? add_z : (nz_src == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we_o <= 1'b0; mem_o <= '0;
      a_we_o   <= 1'b0; a_o   <= '0;
      x_we_o   <= 1'b0; x_o   <= '0;
      s_we_o   <= 1'b0; s_o   <= '0;
      nz_we_o  <= 1'b0; n_o   <= 1'b0; z_o <= 1'b0;
      c_we_o   <= 1'b0; c_o   <= 1'b0;
      v_we_o   <= 1'b0; v_o   <= 1'b0;
    end else begin
      mem_we_o <= nx_mem_we; mem_o <= nx_mem;
      a_we_o   <= nx_a_we;   a_o   <= nx_a;
      x_we_o   <= nx_x_we;   x_o   <= nx_x;
      s_we_o   <= nx_s_we;   s_o   <= nx_s;
      nz_we_o  <= nx_nz_we;  n_o   <= nx_n; z_o <= nx_z;
      c_we_o   <= nx_c_we;   c_o   <= nx_c;
      v_we_o   <= nx_v_we;   v_o   <= nx_v;
    end
  end

endmodule

// File: rtl/rmw_unit_chk.sv
`timescale 1ns/1ps
module rmw_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] x_i,
  input logic [W-1:0] m_i,
  input logic         c_i,
  input logic         mem_we_o,
  input logic [W-1:0] mem_o,
  input logic         a_we_o,
  input logic [W-1:0] a_o,
  input logic         x_we_o,
  input logic [W-1:0] x_o,
  input logic         s_we_o,
  input logic [W-1:0] s_o,
  input logic         nz_we_o,
  input logic         n_o,
  input logic         z_o,
  input logic         c_we_o,
  input logic         c_o,
  input logic         v_we_o,
  input logic         v_o
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !(mem_we_o || a_we_o || x_we_o || s_we_o || nz_we_o || c_we_o || v_we_o));

  a_r2_shl_or: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd0) |=> (mem_o == {$past(m_i[W-2:0]), 1'b0}) &&
                       (a_o == ($past(a_i) | mem_o)) && (c_o == $past(m_i[W-1])));

  a_r5_cmp_keeps_a: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd4) |=> !a_we_o && !v_we_o && (a_o == $past(a_i)));

  a_r7_carry_is_bit7: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd6) |=> c_we_o && (c_o == a_o[W-1]));

  a_r8_rotate_flags: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd7) |=> (a_o[W-1] == $past(c_i)) && (c_o == a_o[W-2]) &&
      (v_o == (($past(a_i[W-1]) & $past(m_i[W-1])) ^ ($past(a_i[W-2]) & $past(m_i[W-2])))));

  a_r10_three_equal: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd9) |=> (a_o == x_o) && (x_o == s_o) && a_we_o && x_we_o && s_we_o);

  a_r12_store_only: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd12) |=> mem_we_o && !nz_we_o && !c_we_o && !v_we_o);

  a_r12_store_ax: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd12) |=> (mem_o == ($past(a_i) & $past(x_i))));

  a_r13_nz_follows_a: assert property (@(posedge clk) disable iff (rst)
    ((op_i <= 4'd2) || (op_i == 4'd6) || (op_i == 4'd7) || (op_i == 4'd10))
      |=> nz_we_o && (n_o == a_o[W-1]) && (z_o == (a_o == '0)));

endmodule

bind rmw_unit rmw_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .a_i      (a_i),
  .x_i      (x_i),
  .m_i      (m_i),
  .c_i      (c_i),
  .mem_we_o (mem_we_o),
  .mem_o    (mem_o),
  .a_we_o   (a_we_o),
  .a_o      (a_o),
  .x_we_o   (x_we_o),
  .x_o      (x_o),
  .s_we_o   (s_we_o),
  .s_o      (s_o),
  .nz_we_o  (nz_we_o),
  .n_o      (n_o),
  .z_o      (z_o),
  .c_we_o   (c_we_o),
  .c_o      (c_o),
  .v_we_o   (v_we_o),
  .v_o      (v_o)
);

// File: tb/rmw_unit_tb.sv
`timescale 1ns/1ps
module rmw_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, x_i = '0, y_i = '0, s_i = '0, m_i = '0;
  logic       c_i = 1'b0, d_i = 1'b0;
  logic       mem_we_o, a_we_o, x_we_o, s_we_o, nz_we_o, c_we_o, v_we_o;
  logic [7:0] mem_o, a_o, x_o, s_o;
  logic       n_o, z_o, c_o, v_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // expected values
  int e_mem, e_a, e_x, e_s;
  bit e_mem_we, e_a_we, e_x_we, e_s_we, e_nz_we, e_c_we, e_v_we;
  bit e_n, e_z, e_c, e_v;

  always #2.5 clk = ~clk;

  rmw_unit u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .x_i(x_i), .y_i(y_i),
    .s_i(s_i), .m_i(m_i), .c_i(c_i), .d_i(d_i),
    .mem_we_o(mem_we_o), .mem_o(mem_o), .a_we_o(a_we_o), .a_o(a_o),
    .x_we_o(x_we_o), .x_o(x_o), .s_we_o(s_we_o), .s_o(s_o),
    .nz_we_o(nz_we_o), .n_o(n_o), .z_o(z_o), .c_we_o(c_we_o), .c_o(c_o),
    .v_we_o(v_we_o), .v_o(v_o)
  );

  function automatic string req_of(int op, bit dd);
    case (op)
      0, 1, 2: return "R2";
      3:       return dd ? "R4" : "R3";
      4:       return "R5";
      5:       return "R6";
      6:       return "R7";
      7:       return "R8";
      8:       return "R9";
      9:       return "R10";
      10, 11:  return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic int sample_val(int k);
    case (k)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      3: return 8'h7F;
      default: return (k * 37 + 11) & 255;
    endcase
  endfunction

  task automatic set_nz(int r);
    e_nz_we = 1; e_n = r[7]; e_z = ((r & 255) == 0);
  endtask

  task automatic model(int op, int a, int x, int y, int s, int m, bit c, bit d);
    int mm, r, lo, hi, t;
    e_mem = m; e_a = a; e_x = x; e_s = s;
    e_mem_we = 0; e_a_we = 0; e_x_we = 0; e_s_we = 0;
    e_nz_we = 0; e_c_we = 0; e_v_we = 0;
    e_n = 0; e_z = 0; e_c = 0; e_v = 0;
    case (op)
      0, 1, 2: begin
        if (op == 0)      begin mm = (m << 1) & 255;       e_a = a | mm; e_c = m[7]; end
        else if (op == 1) begin mm = ((m << 1) | c) & 255; e_a = a & mm; e_c = m[7]; end
        else              begin mm = m >> 1;               e_a = a ^ mm; e_c = m[0]; end
        e_mem = mm; e_mem_we = 1; e_a_we = 1; e_c_we = 1; set_nz(e_a);
      end
      3: begin
        mm = (int'(c) << 7) | (m >> 1);
        t  = m & 1;
        e_mem = mm; e_mem_we = 1; e_a_we = 1; e_c_we = 1; e_v_we = 1; e_nz_we = 1;
        e_z = (((a + mm + t) & 255) == 0);
        if (!d) begin
          r = a + mm + t; e_a = r & 255; e_c = (r > 255);
          e_n = e_a[7];
          e_v = (((~(a ^ mm)) & (a ^ e_a) & 8'h80) != 0);
        end else begin
          lo = (a & 15) + (mm & 15) + t;
          if (lo > 9) lo = lo + 6;
          hi = (a >> 4) + (mm >> 4) + ((lo > 15) ? 1 : 0);
          e_n = ((hi & 8) != 0);
          e_v = (((~(a ^ mm)) & (a ^ (hi << 4)) & 8'h80) != 0);
          if (hi > 9) hi = hi + 6;
          e_c = (hi > 15);
          e_a = ((hi & 15) << 4) | (lo & 15);
        end
      end
      4: begin
        mm = (m - 1) & 255; r = a - mm;
        e_mem = mm; e_mem_we = 1; e_c_we = 1; e_c = (r >= 0); set_nz(r & 255);
      end
      5: begin
        mm = (m + 1) & 255; r = a - mm - (1 - int'(c));
        e_mem = mm; e_mem_we = 1; e_a_we = 1; e_c_we = 1; e_v_we = 1;
        e_c = (r >= 0); set_nz(r & 255);
        e_v = (((a ^ mm) & (a ^ (r & 255)) & 8'h80) != 0);
        if (!d) e_a = r & 255;
        else begin
          lo = (a & 15) - (mm & 15) - (1 - int'(c));
          hi = (a >> 4) - (mm >> 4) - ((lo < 0) ? 1 : 0);
          if (lo < 0) lo = lo - 6;
          if (hi < 0) hi = hi - 6;
          e_a = ((hi & 15) << 4) | (lo & 15);
        end
      end
      6: begin t = a & m; e_a = t; e_a_we = 1; e_c_we = 1; e_c = t[7]; set_nz(t); end
      7: begin
        t = a & m; e_a = (int'(c) << 7) | (t >> 1); e_a_we = 1;
        e_c_we = 1; e_c = e_a[6];
        e_v_we = 1; e_v = (a[6] & m[6]) ^ (a[7] & m[7]);
        set_nz(e_a);
      end
      8: begin
        r = (x & a) - m; e_x = r & 255; e_x_we = 1;
        e_c_we = 1; e_c = (r >= 0); set_nz(e_x);
      end
      9: begin
        t = s & m; e_a = t; e_x = t; e_s = t;
        e_a_we = 1; e_x_we = 1; e_s_we = 1; set_nz(t);
      end
      10: begin e_a = (a | 8'hEE) & x & m; e_a_we = 1; set_nz(e_a); end
      11: begin
        e_a = (a | 8'hEE) & m; e_x = e_a; e_a_we = 1; e_x_we = 1; set_nz(e_a);
      end
      12: begin e_mem = a & x; e_mem_we = 1; end
      13: begin e_mem = x & 7; e_mem_we = 1; end
      14: begin e_mem = y & 7; e_mem_we = 1; end
      default: begin
        e_s = a & x; e_s_we = 1; e_mem = a & x & 7; e_mem_we = 1;
      end
    endcase
  endtask

  task automatic run_vec(int op, int a, int x, int y, int s, int m, bit c, bit d);
    logic [6:0]  ctl_act, ctl_exp;
    logic [35:0] dat_act, dat_exp;
    @(negedge clk);
    op_i = 4'(op); a_i = 8'(a); x_i = 8'(x); y_i = 8'(y); s_i = 8'(s);
    m_i = 8'(m); c_i = c; d_i = d;
    model(op, a, x, y, s, m, c, d);
    @(posedge clk);
    #1;
    // R13: write enables per op
    ctl_act = {mem_we_o, a_we_o, x_we_o, s_we_o, nz_we_o, c_we_o, v_we_o};
    ctl_exp = {e_mem_we, e_a_we, e_x_we, e_s_we, e_nz_we, e_c_we, e_v_we};
    n_checks++;
    if (ctl_act !== ctl_exp) begin
      n_fail++;
      $display("FAIL R13 op=%0d a=%h m=%h: enables actual=%b expected=%b",
               op, a, m, ctl_act, ctl_exp);
    end
    dat_act = {mem_o, a_o, x_o, s_o, n_o, z_o, c_o, v_o};
    dat_exp = {8'(e_mem), 8'(e_a), 8'(e_x), 8'(e_s), e_n, e_z, e_c, e_v};
    n_checks++;
    if (dat_act !== dat_exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h x=%h m=%h c=%0d d=%0d: actual=%h expected=%h",
               req_of(op, d), op, a, x, m, c, d, dat_act, dat_exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: actual=150000 cycles expected=completion earlier");
    finish_run();
  end

  initial begin
    logic [35:0] held;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    n_checks++;
    if ({mem_we_o, a_we_o, x_we_o, s_we_o, nz_we_o, c_we_o, v_we_o,
         mem_o, a_o, x_o, s_o, n_o, z_o, c_o, v_o} !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: actual=%h%h%h%h expected=0", mem_o, a_o, x_o, s_o);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1: output holds until the next edge after inputs change
    run_vec(9, 8'h12, 8'h34, 8'h56, 8'hF0, 8'h3C, 1'b0, 1'b0);
    held = {mem_o, a_o, x_o, s_o, n_o, z_o, c_o, v_o};
    @(negedge clk);
    op_i = 4'd12; a_i = 8'hAA; x_i = 8'h55; m_i = 8'h99;
    #1;
    n_checks++;
    if ({mem_o, a_o, x_o, s_o, n_o, z_o, c_o, v_o} !== held) begin
      n_fail++;
      $display("FAIL R1 latency: actual=%h expected=%h",
               {mem_o, a_o, x_o, s_o, n_o, z_o, c_o, v_o}, held);
    end

    // Sweep all ops with edge and spread operands, both carry and decimal settings
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 24; ia++)
        for (int im = 0; im < 24; im++)
          for (int cd = 0; cd < 4; cd++)
            run_vec(op, sample_val(ia), sample_val((ia + im) % 24),
                    sample_val((ia * 3 + im) % 24), sample_val((im * 5 + ia + op) % 24),
                    sample_val(im), cd[0], cd[1]);

    // R4 and R6: every packed-BCD operand pair through the decimal adder ops
    for (int da = 0; da < 100; da++)
      for (int dm = 0; dm < 100; dm++)
        for (int cc = 0; cc < 2; cc++) begin
          run_vec(3, ((da / 10) << 4) | (da % 10), 8'h11, 8'h22, 8'h33,
                  ((dm / 10) << 4) | (dm % 10), cc[0], 1'b1);
          run_vec(5, ((da / 10) << 4) | (da % 10), 8'h11, 8'h22, 8'h33,
                  ((dm / 10) << 4) | (dm % 10), cc[0], 1'b1);
        end

    // R4: nibbles above 9 (0x0F + 0x0F style and 0x0C + 0x0D style after rotate)
    run_vec(3, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h1E, 1'b0, 1'b1);
    run_vec(3, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h1A, 1'b0, 1'b1);
    run_vec(3, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1);

    finish_run();
  end

endmodule